// File: doc/BRIEF.md
# Cache Line Flush Ordering Tracker

This block sits between a core's in-order request stream and its memory pipeline. It decides, request by request, whether a request may issue this cycle. Each request carries an operation code and a byte address. The requests are loads, stores, semaphores, data-side and instruction-side line flushes, full memory fences and flush-synchronise barriers. Granted flushes are sent out on a dispatch port, each with a slot index. A responder later returns that index on the acknowledge port when the flush has finished.

Flushes are kept in a small table of line addresses. A line is the byte address with its low six bits removed, so lines are 64 bytes. Loads, stores and semaphores never wait for a flush, whether or not they touch the same line. Because the stream is in order, a same-line access always issues after the flush that came before it. A full fence also passes flushes that are still outstanding. Only the flush-synchronise barrier tracks flush completion. A barrier is accepted at once, and a small sequencer then holds fences and further flushes until every flush accepted before the barrier has been acknowledged. The sequencer reports that moment on a retire pulse.

The sequencer has two states:
- RUN: normal operation.
- DRAIN: a barrier is pending.

It has two transitions:
- RUN to DRAIN: a barrier is accepted while the table is not empty.
- DRAIN to RUN: the table has become empty.

Top module: `flush_order_tracker`

## Requirements
- R1: After reset the table is empty, the sequencer is in RUN, `fl_valid` and `sync_done` are low, and a load is granted in the cycle it is presented.
- R2: Op codes are 0 load, 1 store, 2 semaphore, 3 data flush, 4 instruction flush, 5 fence, 6 flush-sync and 7 reserved. Code 7 is granted in RUN and has no effect. A granted flush raises `fl_valid` in the same cycle with `fl_line` = `req_addr[31:6]`, `fl_idx` = the lowest free slot, and `fl_instr` = 1 only for code 4. No other op raises `fl_valid`.
- R3: A load, store or semaphore is granted in the cycle it is presented, in both sequencer states, even when a flush of the same line is outstanding.
- R4: `req_line_hit` is 1 only when a load, store or semaphore is presented and its line matches a valid table entry.
- R5: With all 8 slots holding flushes, a flush is not granted. An acknowledge in cycle t frees its slot at the end of t, and a waiting flush is granted in t+1 into that slot.
- R6: In RUN a fence is granted in the cycle it is presented, whatever flushes are outstanding.
- R7: A flush-sync is granted in RUN in the cycle it is presented. If the table is empty, `sync_done` pulses in that same cycle. Otherwise the sequencer enters DRAIN and `sync_done` pulses in the cycle after the acknowledge that empties the table.
- R8: In DRAIN, fences, flushes, flush-syncs and reserved ops are not granted. They are first granted in the cycle after `sync_done`.
- R9: An acknowledge naming a slot that holds no flush changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented; held until granted |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 32 | Byte address of the request |
| req_grant | output | 1 | Request issues this cycle |
| req_line_hit | output | 1 | Memory access matches an outstanding flush line |
| fl_valid | output | 1 | Flush dispatched this cycle |
| fl_instr | output | 1 | Dispatched flush is instruction-side |
| fl_line | output | 26 | Line address of the dispatched flush |
| fl_idx | output | 3 | Table slot of the dispatched flush |
| ack_valid | input | 1 | Flush completion acknowledge |
| ack_idx | input | 3 | Slot being acknowledged |
| sync_done | output | 1 | Pending flush-sync retires this cycle |

## Verification
The hardest case to reach is a fence waiting behind a pending barrier while the table drains. It needs the table full and a barrier accepted. Then a fence must be held while the acknowledges arrive one per cycle. The bench fills all eight slots, reuses a freed slot for a stalled ninth flush, and accepts the barrier. It then forks the fence request against a responder that acknowledges every slot on consecutive cycles. The fence is expected to be granted exactly one cycle after the retire pulse, and a same-line load slips past the barrier during the drain.

// File: rtl/flt_pkg.sv
package flt_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_SEM    = 3'd2,
        OP_FLUSH  = 3'd3,
        OP_FLUSHI = 3'd4,
        OP_FENCE  = 3'd5,
        OP_FSYNC  = 3'd6,
        OP_RSVD   = 3'd7
    } req_op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } seq_state_e;
endpackage

// File: rtl/flt_line_table.sv
module flt_line_table #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 26,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] alloc_line,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_idx,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    output logic              full,
    output logic              empty
);
    logic [DEPTH-1:0]  valid_q;
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [DEPTH-1:0]  match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                line_q[g]  <= '0;
            end else begin
                if (ack_valid && ack_idx == IDX_W'(g))
                    valid_q[g] <= 1'b0;
                if (alloc_en && alloc_idx == IDX_W'(g)) begin
                    valid_q[g] <= 1'b1;
                    line_q[g]  <= alloc_line;
                end
            end
        end
        assign match[g] = valid_q[g] && (line_q[g] == look_line);
    end

    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i])
                alloc_idx = IDX_W'(i);
        end
    end

    assign look_hit = |match;
    assign full     = &valid_q;
    assign empty    = ~|valid_q;

    // R5
    alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && valid_q[ack_idx]) |=> !valid_q[$past(ack_idx)]);

    // R2
    alloc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> valid_q[$past(alloc_idx)]);
endmodule

// File: rtl/flt_seq_ctrl.sv
module flt_seq_ctrl (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  flt_pkg::req_op_e     req_op,
    input  logic                 full,
    input  logic                 empty,
    output logic                 grant,
    output logic                 alloc_en,
    output logic                 sync_done
);
    import flt_pkg::*;

    seq_state_e state_q, state_d;
    logic       is_mem;
    logic       is_flush;

    assign is_mem   = (req_op == OP_LOAD) || (req_op == OP_STORE) || (req_op == OP_SEM);
    assign is_flush = (req_op == OP_FLUSH) || (req_op == OP_FLUSHI);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (req_valid && req_op == OP_FSYNC && !empty)
                    state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (empty)
                    state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        grant     = 1'b0;
        sync_done = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (is_flush) grant = req_valid && !full;
                else          grant = req_valid;
                sync_done = req_valid && req_op == OP_FSYNC && empty;
            end
            ST_DRAIN: begin
                grant     = req_valid && is_mem;
                sync_done = empty;
            end
        endcase
        alloc_en = grant && is_flush;
    end

    // R8
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !empty) |=> state_q == ST_DRAIN);

    // R3
    mem_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_mem) |-> grant);

    // R7
    sync_done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> empty);
endmodule

// File: rtl/flush_order_tracker.sv
module flush_order_tracker #(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6,
    parameter int DEPTH     = 8,
    localparam int LINE_W   = ADDR_W - LINE_BITS,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_grant,
    output logic              req_line_hit,
    output logic              fl_valid,
    output logic              fl_instr,
    output logic [LINE_W-1:0] fl_line,
    output logic [IDX_W-1:0]  fl_idx,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic              sync_done
);
    import flt_pkg::*;

    req_op_e           op;
    logic [LINE_W-1:0] req_line;
    logic              unused_low;
    logic              alloc_en, look_hit, tbl_full, tbl_empty;
    logic [IDX_W-1:0]  alloc_idx;

    assign op         = req_op_e'(req_op);
    assign req_line   = req_addr[ADDR_W-1:LINE_BITS];
    assign unused_low = ^req_addr[LINE_BITS-1:0];

    flt_line_table #(.DEPTH(DEPTH), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_line (req_line),
        .alloc_idx  (alloc_idx),
        .ack_valid  (ack_valid),
        .ack_idx    (ack_idx),
        .look_line  (req_line),
        .look_hit   (look_hit),
        .full       (tbl_full),
        .empty      (tbl_empty)
    );

    flt_seq_ctrl u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op),
        .full      (tbl_full),
        .empty     (tbl_empty),
        .grant     (req_grant),
        .alloc_en  (alloc_en),
        .sync_done (sync_done)
    );

    assign req_line_hit = req_valid && look_hit &&
                          (op == OP_LOAD || op == OP_STORE || op == OP_SEM);
    assign fl_valid = alloc_en;
    assign fl_instr = alloc_en && op == OP_FLUSHI;
    assign fl_line  = req_line;
    assign fl_idx   = alloc_idx;

    // R2
    dispatch_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> (req_grant && (op == OP_FLUSH || op == OP_FLUSHI)));
endmodule

// File: tb/test_flush_order_tracker.sv
`timescale 1ns/1ps
module test_flush_order_tracker;
    import flt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = '0;
    logic        req_grant, req_line_hit, fl_valid, fl_instr, sync_done;
    logic [25:0] fl_line;
    logic [2:0]  fl_idx;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_idx = 3'd0;

    int n_chk = 0, n_fail = 0, done_cnt = 0;
    bit finished = 0;

    typedef struct { int line; int idx; int instr; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    flush_order_tracker i_flush_order_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_grant(req_grant), .req_line_hit(req_line_hit),
        .fl_valid(fl_valid), .fl_instr(fl_instr), .fl_line(fl_line), .fl_idx(fl_idx),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .sync_done(sync_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_flush(input logic [31:0] a, input int idx, input int instr);
        exp_t e;
        e.line = int'(a >> 6); e.idx = idx; e.instr = instr;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] a,
                        output int waits, output int hit, output int done);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; waits = 0;
        #1;
        while (!req_grant && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        hit = int'(req_line_hit); done = int'(sync_done);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ack(input int idx);
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = 3'(idx);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    // monitor: scoreboard of flush dispatches, count retire pulses
    always @(negedge clk) begin
        #2;
        if (rst_n && fl_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected dispatch", int'(fl_line), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(fl_line) == e.line, "R2 fl_line", int'(fl_line), e.line);
                chk(int'(fl_idx) == e.idx, "R2/R5 fl_idx", int'(fl_idx), e.idx);
                chk(int'(fl_instr) == e.instr, "R2 fl_instr", int'(fl_instr), e.instr);
            end
        end
        if (rst_n && sync_done) done_cnt++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w, h, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(fl_valid == 0, "R1 fl_valid", int'(fl_valid), 0);
        chk(sync_done == 0, "R1 sync_done", int'(sync_done), 0);
        send(OP_LOAD, 32'h1000, w, h, d);
        chk(w == 0, "R1 load waits", w, 0);
        chk(h == 0, "R1 load hit", h, 0);
        // R7 flush-sync on empty table retires at once
        send(OP_FSYNC, 32'h0, w, h, d);
        chk(w == 0 && d == 1, "R7 empty sync", w * 10 + d, 1);

        // R2 dispatch of both flush kinds
        expect_flush(32'h1000, 0, 0);
        send(OP_FLUSH, 32'h1000, w, h, d);
        chk(w == 0, "R2 flush waits", w, 0);
        expect_flush(32'h2040, 1, 1);
        send(OP_FLUSHI, 32'h2040, w, h, d);
        chk(w == 0, "R2 flushi waits", w, 0);

        // R3/R4 same-line and other-line accesses
        send(OP_LOAD, 32'h1008, w, h, d);
        chk(w == 0, "R3 same-line load waits", w, 0);
        chk(h == 1, "R4 same-line load hit", h, 1);
        send(OP_STORE, 32'h3000, w, h, d);
        chk(w == 0 && h == 0, "R4 other-line store", w * 10 + h, 0);
        send(OP_SEM, 32'h2070, w, h, d);
        chk(w == 0 && h == 1, "R3 same-line sem", w * 10 + h, 1);

        // R6 fence passes outstanding flushes
        send(OP_FENCE, 32'h0, w, h, d);
        chk(w == 0, "R6 fence waits", w, 0);

        do_ack(0);
        do_ack(1);
        send(OP_LOAD, 32'h1000, w, h, d);
        chk(h == 0, "R4 hit after ack", h, 0);

        // R2 reserved op granted, no dispatch
        send(OP_RSVD, 32'h1000, w, h, d);
        chk(w == 0, "R2 reserved waits", w, 0);

        // R5 fill all slots
        for (int i = 0; i < 8; i++) begin
            expect_flush(32'h10000 + 32'(i * 64), i, 0);
            send(OP_FLUSH, 32'h10000 + 32'(i * 64), w, h, d);
        end
        expect_flush(32'h20000, 5, 0);
        fork
            begin
                send(OP_FLUSH, 32'h20000, w, h, d);
            end
            begin
                repeat (3) @(negedge clk);
                ack_valid = 1'b1; ack_idx = 3'd5;
                @(negedge clk);
                ack_valid = 1'b0;
            end
        join
        chk(w == 3, "R5 full flush waits", w, 3);

        // R7/R8 barrier with full table
        send(OP_FSYNC, 32'h0, w, h, d);
        chk(w == 0 && d == 0, "R7 sync accept", w * 10 + d, 0);
        send(OP_LOAD, 32'h10000, w, h, d);
        chk(w == 0 && h == 1, "R3 load during drain", w * 10 + h, 1);
        fork
            begin
                send(OP_FENCE, 32'h0, w, h, d);
            end
            begin
                repeat (3) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    ack_valid = 1'b1; ack_idx = 3'(i);
                    @(negedge clk);
                end
                ack_valid = 1'b0;
            end
        join
        chk(w == 11, "R8 fence behind barrier waits", w, 11);
        chk(done_cnt == 2, "R7 retire pulses", done_cnt, 2);

        // R9 acknowledge to an empty slot
        expect_flush(32'h5000, 0, 0);
        send(OP_FLUSH, 32'h5000, w, h, d);
        do_ack(4);
        expect_flush(32'h6000, 1, 0);
        send(OP_FLUSH, 32'h6000, w, h, d);
        send(OP_LOAD, 32'h5000, w, h, d);
        chk(h == 1, "R9 slot kept after stray ack", h, 1);
        do_ack(0);
        do_ack(1);
        send(OP_FSYNC, 32'h0, w, h, d);
        chk(w == 0 && d == 1, "R7 sync after drain", w * 10 + d, 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 dispatches left", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule